// File: doc/BRIEF.md
# Host Byte FIFO with Command Collection

This block sits behind a single host register address of a bus controller and decides where each host byte goes. In command-collect mode every host write lands in a dedicated command buffer, which grows from index 0 until it is full. Outside that mode, host writes and reads go through a small transfer buffer. The transfer buffer has a read pointer, a write pointer and a signed residual count, and both pointers return to zero as soon as a read empties it.

The block also keeps three small registers. The FIFO flags register is loaded when a two-byte status response (the status byte, then a zero message byte) is written into the transfer buffer. The interrupt code and the sequence step are set by a flush command, which also clears the flags. A dropped byte in either buffer produces a one-cycle overrun pulse. A controller sequencer drives the mode, the phase, the flush strobe and the status-response load. The host drives the byte port. A command consumer reads collected bytes by index.

Top module: `host_fifo`

## Requirements
- R1: While `cmd_mode_i` is 1, a host write stores its byte in the command buffer at index `cmd_len_o` and then increments `cmd_len_o`. The byte can be read back on `cmd_byte_o` by placing its index on `cmd_idx_i`.
- R2: While `cmd_len_o` equals CMD_DEPTH (16 by default), a command-mode write is dropped. `cmd_len_o` and the stored bytes stay unchanged, and `overrun_o` is 1 for the following cycle.
- R3: A cycle with `cmd_mode_i` at 0 sets `cmd_len_o` to 0. A command-mode write leaves the transfer buffer and `residual_o` untouched.
- R4: Outside command mode, a host write stores the byte and increments `residual_o`. When the write pointer sits at XFER_DEPTH-1, the write is dropped, `residual_o` is unchanged and `overrun_o` pulses. The buffer therefore holds at most XFER_DEPTH-1 (15) bytes.
- R5: A host read while `phase_i` is 3'b000 (data-out) sets `rd_data_o` to 0 and leaves the pointers and `residual_o` unchanged.
- R6: In any other phase, a read with data pending returns the oldest byte on `rd_data_o` and decrements `residual_o`. A read of an empty buffer changes neither `rd_data_o` nor `residual_o`.
- R7: When a read makes the read pointer equal to the write pointer, both pointers return to 0. After the buffer is drained, another XFER_DEPTH-1 writes are accepted without overrun.
- R8: A flush strobe sets `int_code_o` to 8'h08 (function complete), `seq_step_o` to 0 and `fifo_flags_o` to 0. Flush wins over a status load in the same cycle.
- R9: A status load puts `status_byte_i` and then 8'h00 into the transfer buffer, with read pointer 0 and write pointer 2. It sets `residual_o` and `fifo_flags_o` to 2. In that cycle it overrides any host write or read.
- R10: After reset, `rd_data_o`, `residual_o`, `cmd_len_o`, `fifo_flags_o`, `int_code_o`, `seq_step_o` and `overrun_o` are all 0.
- R11: When a host write and a host read arrive in the same cycle, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_mode_i | input | 1 | 1 = host writes go to the command buffer |
| phase_i | input | 3 | Bus phase bits; 3'b000 is data-out |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Host read strobe |
| flush_i | input | 1 | Flush command strobe |
| status_wr_i | input | 1 | Load the status response into the transfer buffer |
| status_byte_i | input | 8 | Status byte for the response |
| cmd_idx_i | input | 4 | Command buffer read index |
| rd_data_o | output | 8 | Host read result |
| residual_o | output | 6 | Signed residual count of the transfer buffer |
| overrun_o | output | 1 | One-cycle pulse after a dropped byte |
| cmd_len_o | output | 5 | Number of collected command bytes |
| cmd_byte_o | output | 8 | Command byte at `cmd_idx_i` |
| fifo_flags_o | output | 5 | FIFO flags register |
| int_code_o | output | 8 | Interrupt code register |
| seq_step_o | output | 3 | Sequence step register |

## Verification
Every result except `cmd_byte_o` comes from a register. The bench therefore drives a stimulus after a falling edge and reads the effect at the next falling edge, exactly one rising edge later. The overrun pulse is checked in that same cycle and checked again one cycle later to confirm it has cleared. `cmd_byte_o` is a combinational read of the command buffer, so it is sampled a few time units after `cmd_idx_i` changes, with no clock edge in between. The bench never waits more than one edge for a result, so a result that arrives a cycle late is caught as a miscompare.

// File: rtl/host_fifo_pkg.sv
package host_fifo_pkg;

    localparam int BYTE_W  = 8;
    localparam int FLAGS_W = 5;
    localparam int SEQ_W   = 3;
    localparam int PHASE_W = 3;

    // Bus phase encodings seen on the status phase bits
    typedef enum logic [PHASE_W-1:0] {
        PH_DATA_OUT = 3'b000,
        PH_DATA_IN  = 3'b001,
        PH_COMMAND  = 3'b010,
        PH_STATUS   = 3'b011,
        PH_MSG_OUT  = 3'b110,
        PH_MSG_IN   = 3'b111
    } bus_phase_e;

    localparam logic [BYTE_W-1:0] IRQ_FUNC_DONE = 8'h08;

    // Operation applied to the transfer buffer in one cycle
    typedef enum logic [1:0] {
        XOP_IDLE = 2'd0,
        XOP_PUSH = 2'd1,
        XOP_POP  = 2'd2,
        XOP_LOAD = 2'd3
    } xfer_op_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] data;
    } host_req_t;

    // Status load beats host access; a write beats a read;
    // command-mode writes never touch the transfer buffer.
    function automatic xfer_op_e pick_xfer_op(input logic status_ld,
                                              input logic cmd_mode,
                                              input host_req_t req);
        if (status_ld)
            return XOP_LOAD;
        else if (req.wr)
            return cmd_mode ? XOP_IDLE : XOP_PUSH;
        else if (req.rd)
            return XOP_POP;
        else
            return XOP_IDLE;
    endfunction

endpackage

// File: rtl/xfer_buf.sv
module xfer_buf
    import host_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RES_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  xfer_op_e                 op,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic [BYTE_W-1:0]        status_byte,
    input  logic                     dout_phase,
    output logic [BYTE_W-1:0]        rdata,
    output logic signed [RES_W-1:0]  residual,
    output logic                     overrun
);
    localparam int            PW    = $clog2(DEPTH);
    localparam logic [PW-1:0] LIMIT = PW'(DEPTH - 1);
    localparam logic [PW-1:0] TWO   = PW'(2);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     rptr, wptr;

    logic push_ok, pop_ok, last_pop;
    always_comb begin
        push_ok  = (op == XOP_PUSH) && (wptr != LIMIT);
        pop_ok   = (op == XOP_POP) && !dout_phase && (rptr < wptr);
        last_pop = pop_ok && ((rptr + 1'b1) == wptr);
    end

    always_ff @(posedge clk) begin
        if (op == XOP_LOAD) begin
            mem[0] <= status_byte;
            mem[1] <= '0;
        end else if (push_ok) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr     <= '0;
            wptr     <= '0;
            residual <= '0;
            rdata    <= '0;
            overrun  <= 1'b0;
        end else begin
            overrun <= 1'b0;
            unique case (op)
                XOP_PUSH: begin
                    if (push_ok) begin
                        wptr     <= wptr + 1'b1;
                        residual <= residual + 1'b1;
                    end else begin
                        overrun <= 1'b1;
                    end
                end
                XOP_POP: begin
                    if (dout_phase) begin
                        rdata <= '0;
                    end else if (pop_ok) begin
                        rdata    <= mem[rptr];
                        residual <= residual - 1'b1;
                        if (last_pop) begin
                            rptr <= '0;
                            wptr <= '0;
                        end else begin
                            rptr <= rptr + 1'b1;
                        end
                    end
                end
                XOP_LOAD: begin
                    rptr     <= '0;
                    wptr     <= TWO;
                    residual <= RES_W'(2);
                end
                default: ;
            endcase
        end
    end

    a_r6_ptr_order: assert property (@(posedge clk) disable iff (rst)
        rptr <= wptr);

    a_r4_drop_at_limit: assert property (@(posedge clk) disable iff (rst)
        (op == XOP_PUSH) && (wptr == LIMIT)
        |=> (wptr == $past(wptr)) && (residual == $past(residual)) && overrun);

    a_r7_rewind: assert property (@(posedge clk) disable iff (rst)
        (op == XOP_POP) && !dout_phase && (rptr < wptr) && ((rptr + 1'b1) == wptr)
        |=> (rptr == '0) && (wptr == '0));

    a_r5_dout_read: assert property (@(posedge clk) disable iff (rst)
        (op == XOP_POP) && dout_phase
        |=> (rdata == '0) && $stable(residual));

    a_r9_load: assert property (@(posedge clk) disable iff (rst)
        (op == XOP_LOAD) |=> (residual == RES_W'(2)) && (wptr == TWO) && (rptr == '0));

endmodule

// File: rtl/cmd_buf.sv
module cmd_buf
    import host_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode,
    input  logic                          wr,
    input  logic [BYTE_W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0]      rd_idx,
    output logic [$clog2(DEPTH+1)-1:0]    len,
    output logic [BYTE_W-1:0]             rd_byte,
    output logic                          overrun
);
    localparam int            IW   = $clog2(DEPTH);
    localparam int            LW   = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              accept;

    assign accept  = mode && wr && (len != FULL);
    assign rd_byte = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (accept)
            mem[len[IW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len     <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= mode && wr && (len == FULL);
            if (!mode)
                len <= '0;
            else if (accept)
                len <= len + 1'b1;
        end
    end

    a_r2_full_hold: assert property (@(posedge clk) disable iff (rst)
        mode && wr && (len == FULL) |=> (len == FULL) && overrun);

    a_r3_leave_clears: assert property (@(posedge clk) disable iff (rst)
        !mode |=> (len == '0));

    a_r1_append: assert property (@(posedge clk) disable iff (rst)
        mode && wr && (len != FULL) |=> (len == $past(len) + 1'b1));

endmodule

// File: rtl/flag_regs.sv
module flag_regs
    import host_fifo_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               status_ld,
    output logic [FLAGS_W-1:0] flags,
    output logic [BYTE_W-1:0]  int_code,
    output logic [SEQ_W-1:0]   seq_step
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            int_code <= '0;
            seq_step <= '0;
        end else if (flush) begin
            flags    <= '0;
            int_code <= IRQ_FUNC_DONE;
            seq_step <= '0;
        end else if (status_ld) begin
            flags    <= FLAGS_W'(2);
        end
    end

    a_r8_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> (int_code == IRQ_FUNC_DONE) && (flags == '0) && (seq_step == '0));

    a_r9_flags_two: assert property (@(posedge clk) disable iff (rst)
        status_ld && !flush |=> (flags == FLAGS_W'(2)));

endmodule

// File: rtl/host_fifo.sv
module host_fifo
    import host_fifo_pkg::*;
#(
    parameter  int XFER_DEPTH = 16,
    parameter  int CMD_DEPTH  = 16,
    localparam int RES_W      = $clog2(XFER_DEPTH) + 2,
    localparam int IW         = $clog2(CMD_DEPTH),
    localparam int LW         = $clog2(CMD_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_mode_i,
    input  logic [2:0]              phase_i,
    input  logic                    wr_en_i,
    input  logic [7:0]              wr_data_i,
    input  logic                    rd_en_i,
    input  logic                    flush_i,
    input  logic                    status_wr_i,
    input  logic [7:0]              status_byte_i,
    input  logic [IW-1:0]           cmd_idx_i,
    output logic [7:0]              rd_data_o,
    output logic signed [RES_W-1:0] residual_o,
    output logic                    overrun_o,
    output logic [LW-1:0]           cmd_len_o,
    output logic [7:0]              cmd_byte_o,
    output logic [4:0]              fifo_flags_o,
    output logic [7:0]              int_code_o,
    output logic [2:0]              seq_step_o
);
    host_req_t req;
    xfer_op_e  xop;
    logic      dout_phase, cmd_wr, xfer_ovr, cmd_ovr;

    always_comb begin
        req.wr     = wr_en_i;
        req.rd     = rd_en_i;
        req.data   = wr_data_i;
        xop        = pick_xfer_op(status_wr_i, cmd_mode_i, req);
        dout_phase = (phase_i == PH_DATA_OUT);
        cmd_wr     = req.wr && cmd_mode_i && !status_wr_i;
    end

    xfer_buf #(.DEPTH(XFER_DEPTH), .RES_W(RES_W)) u_xfer (
        .clk         (clk),
        .rst         (rst),
        .op          (xop),
        .wdata       (req.data),
        .status_byte (status_byte_i),
        .dout_phase  (dout_phase),
        .rdata       (rd_data_o),
        .residual    (residual_o),
        .overrun     (xfer_ovr)
    );

    cmd_buf #(.DEPTH(CMD_DEPTH)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .mode    (cmd_mode_i),
        .wr      (cmd_wr),
        .wdata   (req.data),
        .rd_idx  (cmd_idx_i),
        .len     (cmd_len_o),
        .rd_byte (cmd_byte_o),
        .overrun (cmd_ovr)
    );

    flag_regs u_flags (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_i),
        .status_ld (status_wr_i),
        .flags     (fifo_flags_o),
        .int_code  (int_code_o),
        .seq_step  (seq_step_o)
    );

    assign overrun_o = xfer_ovr | cmd_ovr;

    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && rd_en_i && !status_wr_i && !cmd_mode_i
        |=> ((residual_o == $past(residual_o) + 1'b1) || overrun_o)
            && $stable(rd_data_o));

    a_r3_cmd_isolated: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && cmd_mode_i && !status_wr_i |=> $stable(residual_o));

    a_r4_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        overrun_o |-> $past(wr_en_i));

endmodule

// File: tb/sim_host_fifo.sv
module sim_host_fifo;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_mode = 1'b0;
    logic [2:0]        phase = 3'b001;
    logic              wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0, st_wr = 1'b0;
    logic [7:0]        wr_data = '0, st_byte = '0;
    logic [3:0]        cmd_idx = '0;
    logic [7:0]        rd_data, cmd_byte, int_code;
    logic signed [5:0] residual;
    logic              overrun;
    logic [4:0]        cmd_len, flags;
    logic [2:0]        seq_step;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    host_fifo u0 (
        .clk(clk), .rst(rst), .cmd_mode_i(cmd_mode), .phase_i(phase),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .flush_i(flush), .status_wr_i(st_wr), .status_byte_i(st_byte),
        .cmd_idx_i(cmd_idx), .rd_data_o(rd_data), .residual_o(residual),
        .overrun_o(overrun), .cmd_len_o(cmd_len), .cmd_byte_o(cmd_byte),
        .fifo_flags_o(flags), .int_code_o(int_code), .seq_step_o(seq_step)
    );

    // op: 0 write, 1 read, 2 flush, 3 idle
    typedef struct packed {
        logic [1:0] op;
        logic       mode;
        logic [2:0] ph;
        logic [7:0] din;
        logic [7:0] exp_rd;
        logic [7:0] exp_res;
        logic       exp_ovr;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd0, 1'b0, 3'd1, 8'hA1, 8'h00, 8'd1, 1'b0},
        '{2'd0, 1'b0, 3'd1, 8'hB2, 8'h00, 8'd2, 1'b0},
        '{2'd0, 1'b0, 3'd1, 8'hC3, 8'h00, 8'd3, 1'b0},
        '{2'd1, 1'b0, 3'd1, 8'h00, 8'hA1, 8'd2, 1'b0},
        '{2'd1, 1'b0, 3'd0, 8'h00, 8'h00, 8'd2, 1'b0},
        '{2'd1, 1'b0, 3'd1, 8'h00, 8'hB2, 8'd1, 1'b0},
        '{2'd1, 1'b0, 3'd1, 8'h00, 8'hC3, 8'd0, 1'b0},
        '{2'd1, 1'b0, 3'd1, 8'h00, 8'hC3, 8'd0, 1'b0},
        '{2'd0, 1'b1, 3'd1, 8'h55, 8'hC3, 8'd0, 1'b0},
        '{2'd0, 1'b0, 3'd1, 8'h66, 8'hC3, 8'd1, 1'b0},
        '{2'd2, 1'b0, 3'd1, 8'h00, 8'hC3, 8'd1, 1'b0},
        '{2'd1, 1'b0, 3'd1, 8'h00, 8'h66, 8'd0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes, wait for one rising edge, sample at falling edge
    task automatic cyc(input logic w, input logic r, input logic f, input logic s,
                       input logic [7:0] d, input logic [7:0] sb);
        wr_en = w; rd_en = r; flush = f; st_wr = s;
        wr_data = d; st_byte = sb;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0; st_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d); cyc(1'b1, 1'b0, 1'b0, 1'b0, d, 8'h00); endtask
    task automatic rd();                    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00); endtask
    task automatic idle();                  cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00); endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 rd_data", rd_data, 0);
        chk("R10 residual", int'(residual), 0);
        chk("R10 cmd_len", cmd_len, 0);
        chk("R10 flags", flags, 0);
        chk("R10 int_code", int_code, 0);
        chk("R10 seq_step", seq_step, 0);
        chk("R10 overrun", overrun, 0);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            string tag;
            cmd_mode = VECS[i].mode;
            phase    = VECS[i].ph;
            case (VECS[i].op)
                2'd0: begin tag = VECS[i].mode ? "R3" : "R4"; wr(VECS[i].din); end
                2'd1: begin tag = (VECS[i].ph == 3'd0) ? "R5" : "R6"; rd(); end
                2'd2: begin tag = "R8"; cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00); end
                default: begin tag = "R6"; idle(); end
            endcase
            chk({tag, " vec rd_data"}, rd_data, VECS[i].exp_rd);
            chk({tag, " vec residual"}, int'(residual), int'(VECS[i].exp_res));
            chk({tag, " vec overrun"}, overrun, VECS[i].exp_ovr);
        end
        chk("R8 int_code after flush", int_code, 8'h08);
        cmd_mode = 1'b0;
        phase    = 3'b001;

        // R4 fill to the limit, then overrun
        for (int i = 0; i < 15; i++) begin
            wr(8'h10 + 8'(i));
            chk("R4 fill residual", int'(residual), i + 1);
        end
        wr(8'hEE);
        chk("R4 overrun pulse", overrun, 1);
        chk("R4 residual held", int'(residual), 15);
        idle();
        chk("R4 overrun clears", overrun, 0);
        // R6 drain in order
        for (int i = 0; i < 15; i++) begin
            rd();
            chk("R6 drain byte", rd_data, 8'h10 + 8'(i));
            chk("R6 drain residual", int'(residual), 14 - i);
        end
        // R7 pointers rewound: full depth-1 accepted again
        for (int i = 0; i < 15; i++) begin
            wr(8'h40 + 8'(i));
            chk("R7 refill overrun", overrun, 0);
        end
        chk("R7 refill residual", int'(residual), 15);
        for (int i = 0; i < 15; i++) rd();
        chk("R7 drained byte", rd_data, 8'h4E);
        chk("R7 drained residual", int'(residual), 0);

        // R11 write and read in the same cycle
        wr(8'h77);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h78, 8'h00);
        chk("R11 residual", int'(residual), 2);
        chk("R11 rd_data held", rd_data, 8'h4E);
        rd();
        chk("R11 first byte", rd_data, 8'h77);
        rd();
        chk("R11 second byte", rd_data, 8'h78);
        chk("R11 residual empty", int'(residual), 0);

        // R9 status response, overriding a host write
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h99, 8'hAB);
        chk("R9 residual", int'(residual), 2);
        chk("R9 flags", flags, 2);
        rd();
        chk("R9 status byte", rd_data, 8'hAB);
        rd();
        chk("R9 message byte", rd_data, 8'h00);
        chk("R9 residual empty", int'(residual), 0);
        rd();
        chk("R6 empty read residual", int'(residual), 0);

        // R8 flush clears flags
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        chk("R8 flags", flags, 0);
        chk("R8 int_code", int_code, 8'h08);
        chk("R8 seq_step", seq_step, 0);

        // R1 / R2 command collection
        cmd_mode = 1'b1;
        for (int i = 0; i < 16; i++) begin
            wr(8'hC0 + 8'(i));
            chk("R1 cmd_len", cmd_len, i + 1);
        end
        for (int i = 0; i < 16; i++) begin
            cmd_idx = 4'(i);
            #1;
            chk("R1 cmd byte", cmd_byte, 8'hC0 + 8'(i));
        end
        @(negedge clk);
        wr(8'hFF);
        chk("R2 overrun", overrun, 1);
        chk("R2 cmd_len", cmd_len, 16);
        cmd_idx = 4'd15;
        #1;
        chk("R2 last byte kept", cmd_byte, 8'hCF);
        chk("R3 residual untouched", int'(residual), 0);
        @(negedge clk);
        // R3 leaving the mode clears the length
        cmd_mode = 1'b0;
        idle();
        chk("R3 cmd_len cleared", cmd_len, 0);
        cmd_mode = 1'b1;
        wr(8'h5A);
        cmd_idx = 4'd0;
        #1;
        chk("R1 restart length", cmd_len, 1);
        chk("R1 restart byte", cmd_byte, 8'h5A);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule